// File: doc/BRIEF.md
# Legacy Adapter Emulation Trap Controller

This block watches host I/O writes aimed at the ports of older monochrome and colour display adapters. When firmware has armed a port class, a write to a port in that class latches a bit that names the port group, and the block raises a trap line. Emulation code can then find out which legacy access it has to reproduce. The legacy mode and colour registers can only be written on the bus. The block keeps shadow copies of them so that firmware can read back what the host program last wrote.

Software reaches every control register through an index/data port pair. It first writes a register index to the index port, then reads or writes the selected register through the data port at the next address. A master enable register can always be reached. Its extended-access bit gates every other register. The same register reports a fixed revision code set by a parameter.

Top module: `legacy_trap_ctrl`

## Requirements
- R1: After reset the trap output is 0. The arm register, the source register, both shadow registers, the index register and the extended-access bit all read as 0.
- R2: The master register sits at index 20h. It reads as {2'b00, ext, 1'b0, VERSION[3:0]}, with VERSION defaulting to 1. Bit 5 of a data write sets ext. Master is reachable whether ext is set or not.
- R3: While ext is 0, data writes to the arm register (index 21h) and to the source register (index 22h) are ignored, and reads of indices 21h through 24h return 0.
- R4: Arm bit 2 traps CRTC writes. A write to the CRTC index port sets source bit 0, and a write to the CRTC data port sets source bit 1. The CRTC index/data ports are 3D4h/3D5h when arm bit 7 is 0 and 3B4h/3B5h when it is 1. The unselected pair never traps.
- R5: Arm bit 3 traps monochrome ports. A write to 3B8h sets source bit 2, and a write to 3BFh sets source bit 4.
- R6: Arm bit 4 traps colour-adapter ports. A write to 3D8h sets source bit 2, and a write to 3D9h sets source bit 3.
- R7: Arm bit 5 traps a write to any port from 3C0h to 3CFh, setting source bit 5. The block's own index port 3CEh and data port 3CFh are exempt.
- R8: Source bits are sticky. A data write to index 22h (with ext set) loads data[5:0], and bits 7:6 always read 0. The trap output is 1 exactly when any source bit is set. It falls in the cycle after software writes 0 to the source register.
- R9: Index 23h reads the last byte written to 3B8h or to 3D8h. The write is captured whether or not it traps and whatever the state of ext.
- R10: Index 24h reads the last 3D9h data in bits 5:0 and bits 1:0 of the last 3BFh write in bits 7:6. Both are captured unconditionally.
- R11: io_rdata is 0 unless io_rd targets the index port, which returns the current index, or the data port. Reads never set source bits. Unassigned indices read 0.
- R12: Data writes to indices 23h and 24h do not change the shadow contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational from register state |
| trap | output | 1 | High while any trap source bit is latched |

## Verification
Assertions check on every cycle several properties. Source bits only clear through a software load, and every trap event lands in the source register. The reserved source bits stay 0, and a write of zero drops the trap. They also check that the arm register holds while extended access is off, that the shadows move only on a capture strobe, and that reads alone never raise a trap. Only the bench scenarios can show the following: which exact port sets which source bit under each arm setting, that the CRTC base switches with arm bit 7, that the block's own port pair is exempt, and that the shadow values match the data the host wrote.

// File: rtl/legacy_trap_pkg.sv
package legacy_trap_pkg;
  localparam int IO_AW = 16;
  localparam int DW    = 8;
  localparam int SRC_W = 6;

  localparam logic [IO_AW-1:0] P_MONO_MODE  = 16'h03B8;
  localparam logic [IO_AW-1:0] P_MONO_CFG   = 16'h03BF;
  localparam logic [IO_AW-1:0] P_CGA_MODE   = 16'h03D8;
  localparam logic [IO_AW-1:0] P_CGA_COLOR  = 16'h03D9;
  localparam logic [IO_AW-1:0] P_CRTC_MONO  = 16'h03B4;
  localparam logic [IO_AW-1:0] P_CRTC_COLOR = 16'h03D4;
  localparam logic [IO_AW-5:0] P_GRP_3C     = 12'h03C;

  // arm register bit positions
  localparam int ARM_CRTC = 2;
  localparam int ARM_MONO = 3;
  localparam int ARM_CGA  = 4;
  localparam int ARM_3CX  = 5;
  localparam int ARM_BASE = 7;

  // source register bit positions
  localparam int SRC_CRTC_IDX = 0;
  localparam int SRC_CRTC_DAT = 1;
  localparam int SRC_MODE     = 2;
  localparam int SRC_COLOR    = 3;
  localparam int SRC_MONOCFG  = 4;
  localparam int SRC_3CX      = 5;

  typedef struct packed {
    logic [SRC_W-1:0] ev;
    logic             cap_mode;
    logic             cap_color;
    logic             cap_mcfg;
  } decode_t;
endpackage

// File: rtl/legacy_trap_decode.sv
module legacy_trap_decode
  import legacy_trap_pkg::*;
#(
  parameter logic [IO_AW-1:0] IDX_PORT = 16'h03CE
) (
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic [DW-1:0]    arm,
  output decode_t          dec
);
  localparam logic [IO_AW-1:0] DAT_PORT = IDX_PORT + 16'd1;

  logic [IO_AW-1:0] crtc_base;
  logic             in_3cx;

  always_comb begin
    crtc_base = arm[ARM_BASE] ? P_CRTC_MONO : P_CRTC_COLOR;
    in_3cx    = (io_addr[IO_AW-1:4] == P_GRP_3C) &&
                (io_addr != IDX_PORT) && (io_addr != DAT_PORT);

    dec = '0;
    dec.ev[SRC_CRTC_IDX] = io_wr && arm[ARM_CRTC] && (io_addr == crtc_base);
    dec.ev[SRC_CRTC_DAT] = io_wr && arm[ARM_CRTC] && (io_addr == crtc_base + 16'd1);
    dec.ev[SRC_MODE]     = io_wr && ((arm[ARM_MONO] && (io_addr == P_MONO_MODE)) ||
                                     (arm[ARM_CGA]  && (io_addr == P_CGA_MODE)));
    dec.ev[SRC_COLOR]    = io_wr && arm[ARM_CGA]  && (io_addr == P_CGA_COLOR);
    dec.ev[SRC_MONOCFG]  = io_wr && arm[ARM_MONO] && (io_addr == P_MONO_CFG);
    dec.ev[SRC_3CX]      = io_wr && arm[ARM_3CX]  && in_3cx;

    dec.cap_mode  = io_wr && ((io_addr == P_MONO_MODE) || (io_addr == P_CGA_MODE));
    dec.cap_color = io_wr && (io_addr == P_CGA_COLOR);
    dec.cap_mcfg  = io_wr && (io_addr == P_MONO_CFG);
  end
endmodule

// File: rtl/legacy_trap_src.sv
module legacy_trap_src
  import legacy_trap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SRC_W-1:0] load_val,
  input  logic [SRC_W-1:0] ev,
  output logic [DW-1:0]    src_q,
  output logic             trap
);
  logic [SRC_W-1:0] bits_q, bits_d;
  logic             bits_en;

  always_comb begin
    bits_en = load || (|ev);
    bits_d  = (load ? load_val : bits_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits_q <= '0;
    else if (bits_en) bits_q <= bits_d;
  end

  assign src_q = {{(DW-SRC_W){1'b0}}, bits_q};
  assign trap  = |bits_q;

  AST_SRC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (($past(src_q) & ~src_q) == '0)); // R8
  AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((src_q[SRC_W-1:0] & $past(ev)) == $past(ev))); // R8
  AST_SRC_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    src_q[DW-1:SRC_W] == '0); // R8
  AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (load_val == '0) && (ev == '0)) |=> !trap); // R8
endmodule

// File: rtl/legacy_trap_regs.sv
module legacy_trap_regs
  import legacy_trap_pkg::*;
#(
  parameter logic [IO_AW-1:0] IDX_PORT = 16'h03CE,
  parameter logic [3:0]       VERSION  = 4'd1,
  parameter logic [DW-1:0]    IDX_MST  = 8'h20,
  parameter logic [DW-1:0]    IDX_ARM  = 8'h21,
  parameter logic [DW-1:0]    IDX_SRC  = 8'h22,
  parameter logic [DW-1:0]    IDX_RBM  = 8'h23,
  parameter logic [DW-1:0]    IDX_RBC  = 8'h24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  input  decode_t          dec,
  input  logic [DW-1:0]    src_q,
  output logic [DW-1:0]    arm_q,
  output logic             src_load,
  output logic [DW-1:0]    io_rdata
);
  localparam logic [IO_AW-1:0] DAT_PORT = IDX_PORT + 16'd1;
  localparam int CW = 2;

  logic [DW-1:0] idx_q, rbm_q, arm_d, rbm_d;
  logic          ext_q, ext_d;
  logic [SRC_W-1:0] color_q, color_d;
  logic [CW-1:0]    mcfg_q, mcfg_d;
  logic wr_idx, wr_dat, idx_en, ext_en, arm_en, rbm_en, color_en, mcfg_en;
  logic [DW-1:0] reg_val;

  always_comb begin
    wr_idx   = io_wr && (io_addr == IDX_PORT);
    wr_dat   = io_wr && (io_addr == DAT_PORT);
    idx_en   = wr_idx;
    ext_en   = wr_dat && (idx_q == IDX_MST);
    ext_d    = io_wdata[5];
    arm_en   = wr_dat && ext_q && (idx_q == IDX_ARM);
    arm_d    = io_wdata;
    src_load = wr_dat && ext_q && (idx_q == IDX_SRC);
    rbm_en   = dec.cap_mode;
    rbm_d    = io_wdata;
    color_en = dec.cap_color;
    color_d  = io_wdata[SRC_W-1:0];
    mcfg_en  = dec.cap_mcfg;
    mcfg_d   = io_wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      ext_q   <= 1'b0;
      arm_q   <= '0;
      rbm_q   <= '0;
      color_q <= '0;
      mcfg_q  <= '0;
    end else begin
      if (idx_en)   idx_q   <= io_wdata;
      if (ext_en)   ext_q   <= ext_d;
      if (arm_en)   arm_q   <= arm_d;
      if (rbm_en)   rbm_q   <= rbm_d;
      if (color_en) color_q <= color_d;
      if (mcfg_en)  mcfg_q  <= mcfg_d;
    end
  end

  always_comb begin
    reg_val = '0;
    if (idx_q == IDX_MST) reg_val = {2'b00, ext_q, 1'b0, VERSION};
    else if (ext_q) begin
      case (idx_q)
        IDX_ARM: reg_val = arm_q;
        IDX_SRC: reg_val = src_q;
        IDX_RBM: reg_val = rbm_q;
        IDX_RBC: reg_val = {mcfg_q, color_q};
        default: reg_val = '0;
      endcase
    end
    if (io_rd && (io_addr == IDX_PORT))      io_rdata = idx_q;
    else if (io_rd && (io_addr == DAT_PORT)) io_rdata = reg_val;
    else                                     io_rdata = '0;
  end

  AST_ARM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && (idx_q == IDX_ARM) && !ext_q) |=> $stable(arm_q)); // R3
  AST_RBM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.cap_mode |=> $stable(rbm_q)); // R9
  AST_RBC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec.cap_color || dec.cap_mcfg) |=> ($stable(color_q) && $stable(mcfg_q))); // R10
endmodule

// File: rtl/legacy_trap_ctrl.sv
module legacy_trap_ctrl
  import legacy_trap_pkg::*;
#(
  parameter logic [IO_AW-1:0] IDX_PORT = 16'h03CE,
  parameter logic [3:0]       VERSION  = 4'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [DW-1:0]    io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic [DW-1:0]    io_rdata,
  output logic             trap
);
  decode_t       dec;
  logic [DW-1:0] arm_q, src_q;
  logic          src_load;

  legacy_trap_decode #(.IDX_PORT(IDX_PORT)) u_decode (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .arm     (arm_q),
    .dec     (dec)
  );

  legacy_trap_regs #(.IDX_PORT(IDX_PORT), .VERSION(VERSION)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .dec      (dec),
    .src_q    (src_q),
    .arm_q    (arm_q),
    .src_load (src_load),
    .io_rdata (io_rdata)
  );

  legacy_trap_src u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (src_load),
    .load_val (io_wdata[SRC_W-1:0]),
    .ev       (dec.ev),
    .src_q    (src_q),
    .trap     (trap)
  );

  AST_NO_TRAP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr && !trap) |=> !trap); // R11
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0)); // R11
endmodule

// File: tb/legacy_trap_ctrl_bench.sv
module legacy_trap_ctrl_bench;
  localparam logic [15:0] IXP = 16'h03CE;
  localparam logic [15:0] DTP = 16'h03CF;
  localparam logic [7:0] I_MST = 8'h20, I_ARM = 8'h21, I_SRC = 8'h22,
                         I_RBM = 8'h23, I_RBC = 8'h24;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic io_wr, io_rd, trap;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_idx, m_arm, m_src, m_rbm, m_rbc;
  logic       m_ext;

  always #5 clk = ~clk;

  legacy_trap_ctrl u_legacy_trap_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .trap(trap)
  );

  function automatic logic [5:0] exp_ev(input logic [15:0] a, input logic [7:0] arm);
    logic [15:0] cb;
    logic [5:0] e;
    cb = arm[7] ? 16'h03B4 : 16'h03D4;
    e = '0;
    e[0] = arm[2] && (a == cb);
    e[1] = arm[2] && (a == cb + 16'd1);
    e[2] = (arm[3] && a == 16'h03B8) || (arm[4] && a == 16'h03D8);
    e[3] = arm[4] && a == 16'h03D9;
    e[4] = arm[3] && a == 16'h03BF;
    e[5] = arm[5] && (a[15:4] == 12'h03C) && a != IXP && a != DTP;
    return e;
  endfunction

  function automatic logic [7:0] exp_reg(input logic [7:0] idx);
    if (idx == I_MST) return {2'b00, m_ext, 1'b0, 4'd1};
    if (!m_ext) return 8'h00;
    case (idx)
      I_ARM: return m_arm;
      I_SRC: return m_src;
      I_RBM: return m_rbm;
      I_RBC: return m_rbc;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    logic [5:0] ev;
    ev = exp_ev(a, m_arm);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    if (a == IXP) m_idx = d;
    else if (a == DTP) begin
      if (m_idx == I_MST) m_ext = d[5];
      else if (m_ext && m_idx == I_ARM) m_arm = d;
      else if (m_ext && m_idx == I_SRC) m_src = d & 8'h3F;
    end
    m_src = m_src | {2'b00, ev};
    if (a == 16'h03B8 || a == 16'h03D8) m_rbm = d;
    if (a == 16'h03D9) m_rbc[5:0] = d[5:0];
    if (a == 16'h03BF) m_rbc[7:6] = d[1:0];
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
    io_write(IXP, idx);
    io_read(DTP, d);
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    io_write(IXP, idx);
    io_write(DTP, d);
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] idx);
    logic [7:0] d;
    reg_rd(idx, d);
    chk(tag, d, exp_reg(idx));
  endtask

  task automatic chk_trap(input string tag);
    chk(tag, {7'b0, trap}, {7'b0, |m_src});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [31:0] r;
    io_addr = '0; io_wdata = '0; io_wr = 0; io_rd = 0;
    m_idx = 0; m_arm = 0; m_src = 0; m_rbm = 0; m_rbc = 0; m_ext = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 trap", {7'b0, trap}, 8'h00);
    io_read(IXP, d); chk("R1 index", d, 8'h00);
    reg_rd(I_MST, d); chk("R2 master reset", d, 8'h01);
    // R3 gated access
    reg_wr(I_ARM, 8'hFF);
    reg_wr(I_SRC, 8'h3F);
    chk("R3 no trap from gated src", {7'b0, trap}, 8'h00);
    chk_reg("R3 arm gated read", I_ARM);
    reg_wr(I_MST, 8'h20);
    reg_rd(I_MST, d); chk("R2 master ext", d, 8'h21);
    reg_rd(I_ARM, d); chk("R3 arm ignored", d, 8'h00);
    reg_rd(I_SRC, d); chk("R1 src zero", d, 8'h00);
    // R4 CRTC colour base
    reg_wr(I_ARM, 8'h04);
    io_write(16'h03D4, 8'h11);
    chk("R4 trap", {7'b0, trap}, 8'h01);
    io_write(16'h03B5, 8'h11);
    reg_rd(I_SRC, d); chk("R4 colour base src", d, 8'h01);
    reg_wr(I_SRC, 8'h00);
    chk("R8 clear", {7'b0, trap}, 8'h00);
    // R4 mono base
    reg_wr(I_ARM, 8'h84);
    io_write(16'h03D5, 8'h22);
    chk("R4 other base ignored", {7'b0, trap}, 8'h00);
    io_write(16'h03B5, 8'h22);
    reg_rd(I_SRC, d); chk("R4 mono base src", d, 8'h02);
    reg_wr(I_SRC, 8'h00);
    // R5
    reg_wr(I_ARM, 8'h08);
    io_write(16'h03B8, 8'h5A);
    io_write(16'h03BF, 8'h03);
    io_write(16'h03D8, 8'h77);
    reg_rd(I_SRC, d); chk("R5 mono src", d, 8'h14);
    reg_rd(I_RBM, d); chk("R9 mode shadow", d, 8'h77);
    reg_wr(I_SRC, 8'h00);
    // R6
    reg_wr(I_ARM, 8'h10);
    io_write(16'h03D8, 8'h2D);
    io_write(16'h03D9, 8'hAB);
    reg_rd(I_SRC, d); chk("R6 cga src", d, 8'h0C);
    io_write(16'h03BF, 8'h01);
    reg_rd(I_RBC, d); chk("R10 colour shadow", d, 8'h6B);
    reg_wr(I_SRC, 8'h00);
    // R7
    reg_wr(I_ARM, 8'h20);
    io_write(16'h03C4, 8'h01);
    reg_rd(I_SRC, d); chk("R7 3cx src", d, 8'h20);
    reg_wr(I_SRC, 8'h00);
    reg_rd(I_SRC, d);
    chk("R7 own ports exempt", {7'b0, trap}, 8'h00);
    // R8 load masks reserved bits
    reg_wr(I_SRC, 8'hFF);
    reg_rd(I_SRC, d); chk("R8 load mask", d, 8'h3F);
    chk("R8 trap on load", {7'b0, trap}, 8'h01);
    reg_wr(I_SRC, 8'h00);
    // R12 shadow writes ignored
    reg_wr(I_RBM, 8'h99);
    reg_rd(I_RBM, d); chk("R12 rbm", d, 8'h2D);
    reg_wr(I_RBC, 8'h00);
    reg_rd(I_RBC, d); chk("R12 rbc", d, 8'h6B);
    // R11
    io_read(16'h03D5, d); chk("R11 foreign read", d, 8'h00);
    #2 chk("R11 idle rdata", io_rdata, 8'h00);
    reg_rd(8'h55, d); chk("R11 unassigned", d, 8'h00);
    reg_wr(I_ARM, 8'hBC);
    io_read(16'h03D9, d); io_read(16'h03C4, d);
    chk("R11 read no trap", {7'b0, trap}, 8'h00);

    // constrained random
    r = $urandom(32'h5EED);
    for (int i = 0; i < 800; i++) begin
      logic [15:0] a;
      logic [7:0]  v;
      int k;
      k = $urandom % 14;
      v = 8'($urandom);
      case (k)
        0: a = 16'h03B4; 1: a = 16'h03B5; 2: a = 16'h03D4; 3: a = 16'h03D5;
        4: a = 16'h03B8; 5: a = 16'h03BF; 6: a = 16'h03D8; 7: a = 16'h03D9;
        8: a = {12'h03C, 4'($urandom)};
        9: a = 16'($urandom);
        10: begin a = IXP; v = 8'h20 + 8'($urandom % 6); end
        default: a = DTP;
      endcase
      if ($urandom % 4 == 0) begin
        io_read(a, d);
        if (a == IXP) chk("R11 rand index read", d, m_idx);
        else if (a == DTP) chk("R3 rand reg read", d, exp_reg(m_idx));
        else chk("R11 rand foreign read", d, 8'h00);
      end else begin
        if (a == DTP && m_idx == I_MST && ($urandom % 4 != 0)) v[5] = 1'b1;
        io_write(a, v);
        chk_trap("R8 rand trap");
      end
      if (i % 50 == 49) begin
        chk_reg("R9 rand rbm", I_RBM);
        chk_reg("R10 rand rbc", I_RBC);
        chk_reg("R2 rand master", I_MST);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule